// File: doc/BRIEF.md
# Byte-Lane Data Bus Inversion Codec

This block sits on the data path of one byte lane of a DRAM interface and processes one beat per clock. On the transmit side it decides, beat by beat, whether the byte goes onto the wires true or inverted, and drives a shared active-low side pin that tells the far end which was chosen. On the receive side it reads that same pin and restores the true byte.

The side pin has a second use. When mask mode is selected, it carries an active-low write mask instead of an inversion flag. A masked beat is marked so that the byte is not stored. Mask mode and write inversion must not be enabled together. If both are requested, the block raises a configuration error and gives mask mode priority. Both paths are registered, so each decoded or encoded beat appears one cycle after its valid input.

Top module: `dbi_lane_codec`

## Requirements
- R1: After reset, both valid outputs are 0, both data outputs are 0, `tx_pin_no` is 1 and `rx_store_o` is 0.
- R2: When write inversion is active, a byte with more than LANE_W/2 zero bits is sent inverted with `tx_pin_no` = 0. Any other byte is sent true with `tx_pin_no` = 1. As a result, the LANE_W+1 transmitted wires never carry more than LANE_W/2 zeros.
- R3: When neither mask mode nor write inversion is enabled, `tx_pin_no` is 1 and `tx_data_o` equals the input byte.
- R4: When read inversion is enabled and mask mode is off, a received beat with pin 0 yields the bitwise complement of `rx_data_i`. A beat with pin 1 yields `rx_data_i` unchanged. In both cases `rx_store_o` is 1.
- R5: When read inversion is disabled and mask mode is off, the receive pin is ignored: `rx_data_o` equals `rx_data_i` and `rx_store_o` is 1 for either pin value.
- R6: In mask mode, `tx_pin_no` equals `tx_keep_i` (0 means masked), and `tx_data_o` is the input byte uninverted whatever its zero count.
- R7: In mask mode, `rx_store_o` equals the sampled receive pin (0 means masked, do not store), and `rx_data_o` is `rx_data_i` uninverted.
- R8: `cfg_err_o` is 1 exactly when mask mode and write inversion are both enabled. In that case the transmit path behaves as in mask mode.
- R9: Each registered output reflects the beat that was valid one clock earlier. When no beat is valid, the valid output drops to 0 and the data, pin and store outputs keep their last values.
- R10: Back-to-back beats are coded independently. Each beat's flag or mask decision depends only on that beat and the mode in force in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mask_en_i | input | 1 | Selects the write-mask use of the side pin |
| cfg_wr_inv_en_i | input | 1 | Enables inversion coding on transmit |
| cfg_rd_inv_en_i | input | 1 | Enables inversion decoding on receive |
| cfg_err_o | output | 1 | Illegal mode combination (mask and write inversion) |
| tx_valid_i | input | 1 | Transmit beat valid |
| tx_data_i | input | LANE_W | Transmit byte, true polarity |
| tx_keep_i | input | 1 | In mask mode, 1 keeps the byte and 0 masks it |
| tx_valid_o | output | 1 | Registered transmit beat valid |
| tx_data_o | output | LANE_W | Byte for the lane wires |
| tx_pin_no | output | 1 | Shared side pin: inversion flag or mask, active low |
| rx_valid_i | input | 1 | Receive beat valid |
| rx_data_i | input | LANE_W | Byte as received from the lane wires |
| rx_pin_ni | input | 1 | Received side pin value |
| rx_valid_o | output | 1 | Registered receive beat valid |
| rx_data_o | output | LANE_W | Restored true byte |
| rx_store_o | output | 1 | 1 when the beat is to be stored, 0 when masked |

## Verification
The bench builds the block with its default LANE_W of 8. At that width, every one of the 256 byte values can be sent through both paths under all eight combinations of the three mode bits. This covers each zero count on both sides of the four-zero threshold, the illegal mask-plus-inversion setting, and both pin values in every mode. Beats run back to back, with an idle cycle inserted at regular intervals, so that latency, hold behaviour and per-beat independence are all checked in the same sweep.

// File: rtl/dbi_lane_pkg.sv
package dbi_lane_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_INV   = 2'd1,
    MODE_MASK  = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/dbi_mode_ctl.sv
module dbi_mode_ctl
  import dbi_lane_pkg::*;
(
  input  logic       mask_en_i,
  input  logic       wr_inv_en_i,
  input  logic       rd_inv_en_i,
  output lane_mode_e tx_mode_o,
  output lane_mode_e rx_mode_o,
  output logic       cfg_err_o
);
  // mask wins over write inversion
  always_comb begin
    if (mask_en_i)        tx_mode_o = MODE_MASK;
    else if (wr_inv_en_i) tx_mode_o = MODE_INV;
    else                  tx_mode_o = MODE_PLAIN;

    if (mask_en_i)        rx_mode_o = MODE_MASK;
    else if (rd_inv_en_i) rx_mode_o = MODE_INV;
    else                  rx_mode_o = MODE_PLAIN;

    cfg_err_o = mask_en_i & wr_inv_en_i;
  end
endmodule

// File: rtl/dbi_tx_enc.sv
module dbi_tx_enc
  import dbi_lane_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lane_mode_e        mode_i,
  input  logic              valid_i,
  input  logic [LANE_W-1:0] data_i,
  input  logic              keep_i,
  output logic              valid_o,
  output logic [LANE_W-1:0] data_o,
  output logic              pin_no
);
  localparam int ZW   = $clog2(LANE_W + 1);
  localparam int HALF = LANE_W / 2;
  localparam logic [ZW-1:0] HALF_Z = ZW'(HALF);

  logic [ZW-1:0]     zcnt;
  logic              inv_sel;
  logic [LANE_W-1:0] data_d;
  logic              pin_d;
  lane_mode_e        mode_q;

  always_comb begin
    zcnt = '0;
    for (int i = 0; i < LANE_W; i++) zcnt = zcnt + ZW'(!data_i[i]);
  end

  assign inv_sel = (mode_i == MODE_INV) && (zcnt > HALF_Z);

  always_comb begin
    data_d = data_i;
    pin_d  = 1'b1;
    unique case (mode_i)
      MODE_MASK: pin_d = keep_i;
      MODE_INV: begin
        data_d = inv_sel ? ~data_i : data_i;
        pin_d  = ~inv_sel;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      pin_no  <= 1'b1;
      mode_q  <= MODE_PLAIN;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= data_d;
        pin_no <= pin_d;
        mode_q <= mode_i;
      end
    end
  end

  p_zero_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == MODE_INV) |-> ($countones({data_o, pin_no}) >= LANE_W + 1 - HALF));

  p_flag_high_plain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == MODE_PLAIN) |-> pin_no);

  p_mask_true_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_MASK) |=> (data_o == $past(data_i) && pin_no == $past(keep_i)));

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(data_o) && $stable(pin_no)));
endmodule

// File: rtl/dbi_rx_dec.sv
module dbi_rx_dec
  import dbi_lane_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lane_mode_e        mode_i,
  input  logic              valid_i,
  input  logic [LANE_W-1:0] data_i,
  input  logic              pin_ni,
  output logic              valid_o,
  output logic [LANE_W-1:0] data_o,
  output logic              store_o
);
  logic [LANE_W-1:0] data_d;
  logic              store_d;

  always_comb begin
    data_d  = data_i;
    store_d = 1'b1;
    unique case (mode_i)
      MODE_MASK: store_d = pin_ni;
      MODE_INV:  data_d  = pin_ni ? data_i : ~data_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      store_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o  <= data_d;
        store_o <= store_d;
      end
    end
  end

  p_plain_ignores_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_PLAIN) |=> (data_o == $past(data_i) && store_o));

  p_mask_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_MASK) |=> (store_o == $past(pin_ni) && data_o == $past(data_i)));

  p_rx_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: rtl/dbi_lane_codec.sv
module dbi_lane_codec
  import dbi_lane_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mask_en_i,
  input  logic              cfg_wr_inv_en_i,
  input  logic              cfg_rd_inv_en_i,
  output logic              cfg_err_o,
  input  logic              tx_valid_i,
  input  logic [LANE_W-1:0] tx_data_i,
  input  logic              tx_keep_i,
  output logic              tx_valid_o,
  output logic [LANE_W-1:0] tx_data_o,
  output logic              tx_pin_no,
  input  logic              rx_valid_i,
  input  logic [LANE_W-1:0] rx_data_i,
  input  logic              rx_pin_ni,
  output logic              rx_valid_o,
  output logic [LANE_W-1:0] rx_data_o,
  output logic              rx_store_o
);
  lane_mode_e tx_mode;
  lane_mode_e rx_mode;

  dbi_mode_ctl u_mode (
    .mask_en_i   (cfg_mask_en_i),
    .wr_inv_en_i (cfg_wr_inv_en_i),
    .rd_inv_en_i (cfg_rd_inv_en_i),
    .tx_mode_o   (tx_mode),
    .rx_mode_o   (rx_mode),
    .cfg_err_o   (cfg_err_o)
  );

  dbi_tx_enc #(.LANE_W(LANE_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (tx_mode),
    .valid_i (tx_valid_i),
    .data_i  (tx_data_i),
    .keep_i  (tx_keep_i),
    .valid_o (tx_valid_o),
    .data_o  (tx_data_o),
    .pin_no  (tx_pin_no)
  );

  dbi_rx_dec #(.LANE_W(LANE_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (rx_mode),
    .valid_i (rx_valid_i),
    .data_i  (rx_data_i),
    .pin_ni  (rx_pin_ni),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .store_o (rx_store_o)
  );

  p_mask_priority_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mask_en_i |-> (tx_mode == MODE_MASK && rx_mode == MODE_MASK));
endmodule

// File: tb/dbi_lane_codec_tb.sv
module dbi_lane_codec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mask_en = 0, wr_inv = 0, rd_inv = 0;
  logic cfg_err;
  logic tx_v = 0, tx_keep = 0;
  logic [W-1:0] tx_d = '0;
  logic tx_vo, tx_pin;
  logic [W-1:0] tx_do;
  logic rx_v = 0, rx_pin = 1;
  logic [W-1:0] rx_d = '0;
  logic rx_vo, rx_store;
  logic [W-1:0] rx_do;

  int total = 0;
  int bad = 0;

  // expected registered state
  logic         e_tx_v = 0, e_tx_pin = 1, e_rx_v = 0, e_rx_store = 0;
  logic [W-1:0] e_tx_d = '0, e_rx_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbi_lane_codec #(.LANE_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_mask_en_i(mask_en), .cfg_wr_inv_en_i(wr_inv), .cfg_rd_inv_en_i(rd_inv),
    .cfg_err_o(cfg_err),
    .tx_valid_i(tx_v), .tx_data_i(tx_d), .tx_keep_i(tx_keep),
    .tx_valid_o(tx_vo), .tx_data_o(tx_do), .tx_pin_no(tx_pin),
    .rx_valid_i(rx_v), .rx_data_i(rx_d), .rx_pin_ni(rx_pin),
    .rx_valid_o(rx_vo), .rx_data_o(rx_do), .rx_store_o(rx_store)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h mode=%b%b%b", req, act, exp, mask_en, wr_inv, rd_inv);
    end
  endtask

  function automatic string tx_req();
    if (mask_en) return "R6";
    if (wr_inv)  return "R2";
    return "R3";
  endfunction

  function automatic string rx_req();
    if (mask_en) return "R7";
    if (rd_inv)  return "R4";
    return "R5";
  endfunction

  // at a negedge: check outputs of the previous cycle, then apply the next beat
  task automatic step(input logic v, input logic [W-1:0] d, input logic keep,
                      input logic pin, input logic m, input logic wi, input logic ri);
    int zeros;
    @(negedge clk);
    chk("R9 tx_valid", tx_vo, e_tx_v);
    chk("R9 rx_valid", rx_vo, e_rx_v);
    chk({tx_req(), " R10 tx_data"}, tx_do, e_tx_d);
    chk({tx_req(), " R10 tx_pin"}, tx_pin, e_tx_pin);
    chk({rx_req(), " rx_data"}, rx_do, e_rx_d);
    chk({rx_req(), " rx_store"}, rx_store, e_rx_store);
    mask_en = m; wr_inv = wi; rd_inv = ri;
    tx_v = v; tx_d = d; tx_keep = keep;
    rx_v = v; rx_d = ~d; rx_pin = pin;
    #1;
    chk("R8 cfg_err", cfg_err, m & wi);
    e_tx_v = v; e_rx_v = v;
    if (v) begin
      zeros = W - $countones(d);
      if (m) begin
        e_tx_d = d; e_tx_pin = keep;
      end else if (wi) begin
        e_tx_d   = (zeros > W/2) ? ~d : d;
        e_tx_pin = !(zeros > W/2);
      end else begin
        e_tx_d = d; e_tx_pin = 1'b1;
      end
      if (m) begin
        e_rx_d = ~d; e_rx_store = pin;
      end else if (ri) begin
        e_rx_d = pin ? ~d : d; e_rx_store = 1'b1;
      end else begin
        e_rx_d = ~d; e_rx_store = 1'b1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    chk("R1 tx_valid", tx_vo, 0);
    chk("R1 rx_valid", rx_vo, 0);
    chk("R1 tx_data", tx_do, 0);
    chk("R1 rx_data", rx_do, 0);
    chk("R1 tx_pin", tx_pin, 1);
    chk("R1 rx_store", rx_store, 0);
    rst_n = 1'b1;
    for (int mode = 0; mode < 8; mode++) begin
      for (int b = 0; b < 256; b++) begin
        logic [W-1:0] d;
        d = W'(b);
        // idle beat every 16th to check hold (R9)
        step(1'b1, d, d[0], d[1] ^ d[3], mode[2], mode[1], mode[0]);
        if (b % 16 == 15)
          step(1'b0, ~d, ~d[0], ~(d[1] ^ d[3]), mode[2], mode[1], mode[0]);
      end
    end
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule